// File: doc/BRIEF.md
# Partial-Tag Data TLB with Deferred Canonical Fault

This block is a small, fully associative data TLB that sits beside a load pipeline. A load presents its virtual address and receives a physical page number, a hit indication and a permission to forward data speculatively, all in the same cycle. Entries are installed through a fill port and discarded by a flush that is raised on every address-space switch.

The tag compare looks only at the lower, canonical part of the virtual page number and ignores the sign-extension bits above it. As a result, an address whose upper bits are not a proper sign extension can still hit an entry that was filled for a canonical address. The speculative path then proceeds with that entry's translation. The canonical test runs in parallel on the full address and produces a flag. That flag is stored against the load's tag in a per-tag slot state machine. It becomes a fault only when the load later retires in program order.

Each TLB entry has two states. `EN_EMPTY` moves to `EN_LIVE` on a write. `EN_LIVE` moves back to `EN_EMPTY` on a flush, and stays in `EN_LIVE` on a re-write. Each load-tag slot has three states: `SL_IDLE`, `SL_CLEAN` and `SL_TAINTED`. A lookup moves a slot from any state to `SL_CLEAN` for a canonical address or to `SL_TAINTED` for a non-canonical one; if a retire names the same tag in that cycle, the lookup wins. A retire moves `SL_CLEAN` or `SL_TAINTED` back to `SL_IDLE`. A replacement pointer walks round-robin across the entries.

Top module: `ptlb_dtlb`

## Requirements
- R1: After reset, every lookup misses, `lk_spec_ok` and `lk_hit` are 0, and `rt_out_valid` is 0.
- R2: A fill written at a clock edge is visible to a lookup from the following cycle: `lk_hit`=1 and `lk_ppn` equals the filled PPN, combinationally in the lookup cycle.
- R3: The hit compare uses only virtual address bits 47:12. Bits 63:48 have no effect on `lk_hit` or `lk_ppn`.
- R4: `lk_noncanon` is 1 exactly when bits 63:47 of `lk_vaddr` are not all equal. It is combinational and does not depend on hit or miss.
- R5: A non-canonical address whose bits 47:12 match a live entry gives `lk_hit`=1, `lk_spec_ok`=1 while `lk_valid`=1, and that entry's PPN.
- R6: On a miss, `lk_spec_ok`=0 and `lk_ppn`=0.
- R7: One cycle after `rt_valid`, `rt_out_valid`=1, `rt_out_ltag` equals the retired tag, and `rt_fault` equals the non-canonical flag of the latest lookup made with that tag. `rt_fault` is 0 whenever `rt_out_valid` is 0.
- R8: A flush empties every entry. From the next cycle, all lookups miss.
- R9: A fill whose VPN matches a live entry overwrites that entry's PPN. It does not advance the replacement pointer and does not create a duplicate.
- R10: A fill with a new VPN writes the entry at the round-robin pointer (entry 0 after reset or flush), and the pointer then advances with a wrap. The 17th distinct fill after a flush evicts the first one.
- R11: When a fill and a flush happen in the same cycle, the flush wins and the fill is dropped.
- R12: A retire of a tag that has no recorded lookup (slot `SL_IDLE`) gives `rt_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A load is looking up this cycle |
| lk_vaddr | input | 64 | Load virtual address |
| lk_ltag | input | 4 | Load tag used to track the load to retirement |
| lk_hit | output | 1 | Partial-tag match against a live entry |
| lk_spec_ok | output | 1 | Load may forward data speculatively |
| lk_ppn | output | 28 | Translated physical page number (0 on miss) |
| lk_noncanon | output | 1 | Address fails the full canonical test |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 36 | VPN to install (address bits 47:12) |
| fill_ppn | input | 28 | PPN to install |
| flush | input | 1 | Discard all entries (address-space switch) |
| rt_valid | input | 1 | A load retires this cycle |
| rt_ltag | input | 4 | Tag of the retiring load |
| rt_out_valid | output | 1 | Retire check result is valid |
| rt_out_ltag | output | 4 | Tag the result belongs to |
| rt_fault | output | 1 | Retiring load had a non-canonical address |

## Verification
The lookup results (hit, speculative permission, PPN, non-canonical flag) have no register between input and output. The bench therefore drives them just after a falling edge and samples a few nanoseconds later, before the next rising edge. Fills and flushes take effect at the next rising edge, so their checks look up in the cycle after that edge. The retire result is registered once and is sampled on the falling edge that follows the rising edge at which `rt_valid` was taken. Eviction and overwrite are observed only through later lookups.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    typedef enum logic {
        EN_EMPTY,
        EN_LIVE
    } ent_state_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_CLEAN,
        SL_TAINTED
    } slot_state_e;

endpackage

// File: rtl/ptlb_canon_chk.sv
module ptlb_canon_chk #(
    parameter int VA_W    = 64,
    parameter int CANON_W = 48,
    localparam int HI_W   = VA_W - CANON_W + 1
) (
    input  logic [HI_W-1:0] hi_bits,
    output logic            noncanon
);

    // canonical when the sign bit and everything above it agree
    always_comb begin
        noncanon = !((&hi_bits) || (~|hi_bits));
    end

endmodule

// File: rtl/ptlb_entry_array.sv
module ptlb_entry_array
    import ptlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 28,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn
);

    ent_state_e          st_q  [ENTRIES];
    logic [VPN_W-1:0]    vpn_q [ENTRIES];
    logic [PPN_W-1:0]    ppn_q [ENTRIES];
    logic [ENTRIES-1:0]  live;
    logic [ENTRIES-1:0]  lk_match;
    logic [ENTRIES-1:0]  fl_match;
    logic [ENTRIES-1:0]  wr_en;
    logic                fl_any;
    logic                fill_take;
    logic [IDX_W-1:0]    rr_q;
    logic [IDX_W-1:0]    rr_nxt;

    assign fill_take = fill_valid && !flush;
    assign fl_any    = |fl_match;

    always_comb begin
        if (rr_q == IDX_W'(ENTRIES - 1)) begin
            rr_nxt = '0;
        end else begin
            rr_nxt = rr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign live[i]     = (st_q[i] == EN_LIVE);
        assign lk_match[i] = live[i] && (vpn_q[i] == lk_vpn);
        assign fl_match[i] = live[i] && (vpn_q[i] == fill_vpn);
        assign wr_en[i]    = fill_take &&
                             (fl_any ? fl_match[i] : (rr_q == IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]  <= EN_EMPTY;
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end else begin
                unique case (st_q[i])
                    EN_EMPTY: begin
                        if (!flush && wr_en[i]) begin
                            st_q[i] <= EN_LIVE;
                        end
                    end
                    EN_LIVE: begin
                        if (flush) begin
                            st_q[i] <= EN_EMPTY;
                        end
                    end
                    default: st_q[i] <= EN_EMPTY;
                endcase
                if (wr_en[i]) begin
                    vpn_q[i] <= fill_vpn;
                    ppn_q[i] <= fill_ppn;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (flush) begin
            rr_q <= '0;
        end else if (fill_valid && !fl_any) begin
            rr_q <= rr_nxt;
        end
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn = lk_ppn | ppn_q[i];
            end
        end
        lk_hit = |lk_match;
    end

    AST_LOOKUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R9
    AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_match)); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (live == '0)); // R8
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take |=> (live != '0)); // R2
    AST_REFILL_SAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && fl_any) |=> ($countones(live) == $past($countones(live)))); // R9
    AST_REFILL_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && fl_any) |=> $stable(rr_q)); // R9
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_valid) |=> (rr_q == '0 && live == '0)); // R11

endmodule

// File: rtl/ptlb_retire_track.sv
module ptlb_retire_track
    import ptlb_pkg::*;
#(
    parameter int LTAG_W = 4,
    localparam int NSLOT = 1 << LTAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [LTAG_W-1:0] rec_ltag,
    input  logic              rec_bad,
    input  logic              rt_valid,
    input  logic [LTAG_W-1:0] rt_ltag,
    output logic              rt_out_valid,
    output logic [LTAG_W-1:0] rt_out_ltag,
    output logic              rt_fault
);

    logic [NSLOT-1:0] tainted;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        slot_state_e cur_q;
        slot_state_e nxt;
        logic        hit_rec;
        logic        hit_ret;

        assign hit_rec = rec_valid && (rec_ltag == LTAG_W'(s));
        assign hit_ret = rt_valid  && (rt_ltag  == LTAG_W'(s));

        always_comb begin
            nxt = cur_q;
            unique case (cur_q)
                SL_IDLE: begin
                    if (hit_rec) begin
                        nxt = rec_bad ? SL_TAINTED : SL_CLEAN;
                    end
                end
                SL_CLEAN, SL_TAINTED: begin
                    if (hit_rec) begin
                        nxt = rec_bad ? SL_TAINTED : SL_CLEAN;
                    end else if (hit_ret) begin
                        nxt = SL_IDLE;
                    end
                end
                default: nxt = SL_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q <= SL_IDLE;
            end else begin
                cur_q <= nxt;
            end
        end

        assign tainted[s] = (cur_q == SL_TAINTED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_out_valid <= 1'b0;
            rt_out_ltag  <= '0;
            rt_fault     <= 1'b0;
        end else begin
            rt_out_valid <= rt_valid;
            rt_out_ltag  <= rt_ltag;
            rt_fault     <= rt_valid && tainted[rt_ltag];
        end
    end

    AST_RETIRE_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |=> (rt_out_valid && rt_out_ltag == $past(rt_ltag))); // R7
    AST_FAULT_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_out_valid |-> !rt_fault); // R7

endmodule

// File: rtl/ptlb_dtlb.sv
module ptlb_dtlb #(
    parameter int VA_W    = 64,
    parameter int CANON_W = 48,
    parameter int PAGE_W  = 12,
    parameter int PPN_W   = 28,
    parameter int ENTRIES = 16,
    parameter int LTAG_W  = 4,
    localparam int VPN_W  = CANON_W - PAGE_W,
    localparam int HI_W   = VA_W - CANON_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [LTAG_W-1:0] lk_ltag,
    output logic              lk_hit,
    output logic              lk_spec_ok,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_noncanon,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              flush,
    input  logic              rt_valid,
    input  logic [LTAG_W-1:0] rt_ltag,
    output logic              rt_out_valid,
    output logic [LTAG_W-1:0] rt_out_ltag,
    output logic              rt_fault
);

    logic [VPN_W-1:0] lk_vpn;
    logic [HI_W-1:0]  lk_hi;
    logic             unused_offset;

    assign lk_vpn        = lk_vaddr[CANON_W-1:PAGE_W];
    assign lk_hi         = lk_vaddr[VA_W-1:CANON_W-1];
    assign unused_offset = ^lk_vaddr[PAGE_W-1:0];

    ptlb_canon_chk #(
        .VA_W    (VA_W),
        .CANON_W (CANON_W)
    ) i_canon (
        .hi_bits  (lk_hi),
        .noncanon (lk_noncanon)
    );

    ptlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_valid (fill_valid),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_ppn     (lk_ppn)
    );

    // speculative forwarding needs a (partial) hit; canonicality is not consulted
    assign lk_spec_ok = lk_valid && lk_hit;

    ptlb_retire_track #(
        .LTAG_W (LTAG_W)
    ) i_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .rec_valid    (lk_valid),
        .rec_ltag     (lk_ltag),
        .rec_bad      (lk_noncanon),
        .rt_valid     (rt_valid),
        .rt_ltag      (rt_ltag),
        .rt_out_valid (rt_out_valid),
        .rt_out_ltag  (rt_out_ltag),
        .rt_fault     (rt_fault)
    );

    AST_MISS_ZERO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0)); // R6
    AST_SPEC_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_spec_ok |-> lk_hit); // R1
    AST_ALIAS_PROCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_noncanon && lk_hit) |-> lk_spec_ok); // R5
    AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit); // R8

endmodule

// File: tb/test_ptlb_dtlb.sv
module test_ptlb_dtlb;

    localparam int PPN_W = 28;
    localparam int VPN_W = 36;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [63:0]       lk_vaddr = '0;
    logic [3:0]        lk_ltag = '0;
    logic              lk_hit;
    logic              lk_spec_ok;
    logic [PPN_W-1:0]  lk_ppn;
    logic              lk_noncanon;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [PPN_W-1:0]  fill_ppn = '0;
    logic              flush = 1'b0;
    logic              rt_valid = 1'b0;
    logic [3:0]        rt_ltag = '0;
    logic              rt_out_valid;
    logic [3:0]        rt_out_ltag;
    logic              rt_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ptlb_dtlb i_ptlb_dtlb (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_vaddr     (lk_vaddr),
        .lk_ltag      (lk_ltag),
        .lk_hit       (lk_hit),
        .lk_spec_ok   (lk_spec_ok),
        .lk_ppn       (lk_ppn),
        .lk_noncanon  (lk_noncanon),
        .fill_valid   (fill_valid),
        .fill_vpn     (fill_vpn),
        .fill_ppn     (fill_ppn),
        .flush        (flush),
        .rt_valid     (rt_valid),
        .rt_ltag      (rt_ltag),
        .rt_out_valid (rt_out_valid),
        .rt_out_ltag  (rt_out_ltag),
        .rt_fault     (rt_fault)
    );

    typedef enum logic [1:0] { OP_FILL, OP_LOOK, OP_FLUSH } op_e;

    typedef struct packed {
        op_e             op;
        logic [63:0]     va;
        logic [PPN_W-1:0] ppn;
        logic            e_hit;
        logic            e_nc;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{OP_LOOK,  64'h0000_0000_1234_5000, 28'h0,       1'b0, 1'b0}, // R1 empty
        '{OP_FILL,  64'h0000_0000_1234_5000, 28'hABCDE01, 1'b0, 1'b0},
        '{OP_LOOK,  64'h0000_0000_1234_5000, 28'hABCDE01, 1'b1, 1'b0}, // R2
        '{OP_LOOK,  64'hDEAD_0000_1234_5ABC, 28'hABCDE01, 1'b1, 1'b1}, // R3 R5
        '{OP_LOOK,  64'hFFFF_0000_1234_5000, 28'hABCDE01, 1'b1, 1'b1}, // R3 R4
        '{OP_FILL,  64'hFFFF_8000_0000_1000, 28'h0000777, 1'b0, 1'b0},
        '{OP_LOOK,  64'hFFFF_8000_0000_1000, 28'h0000777, 1'b1, 1'b0}, // R4 canonical high
        '{OP_LOOK,  64'h0000_8000_0000_1000, 28'h0000777, 1'b1, 1'b1}, // R5 alias of high
        '{OP_LOOK,  64'h0000_0000_0000_2000, 28'h0,       1'b0, 1'b0}, // R6
        '{OP_LOOK,  64'h0001_0000_0000_2000, 28'h0,       1'b0, 1'b1}, // R4 on miss
        '{OP_FLUSH, 64'h0,                   28'h0,       1'b0, 1'b0},
        '{OP_LOOK,  64'h0000_0000_1234_5000, 28'h0,       1'b0, 1'b0}  // R8
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_ppn   = ppn;
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    task automatic do_look(input string req, input logic [63:0] va, input logic [3:0] tag,
                           input logic e_hit, input logic e_nc, input logic [PPN_W-1:0] e_ppn);
        lk_valid = 1'b1;
        lk_vaddr = va;
        lk_ltag  = tag;
        #2;
        chk({req, " hit"},     64'(lk_hit),      64'(e_hit));
        chk({req, " spec_ok"}, 64'(lk_spec_ok),  64'(e_hit));
        chk({req, " noncanon"},64'(lk_noncanon), 64'(e_nc));
        chk({req, " ppn"},     64'(lk_ppn),      64'(e_hit ? e_ppn : '0));
        tick();
        lk_valid = 1'b0;
    endtask

    task automatic do_retire(input string req, input logic [3:0] tag, input logic e_fault);
        rt_valid = 1'b1;
        rt_ltag  = tag;
        tick();
        rt_valid = 1'b0;
        chk({req, " rt_out_valid"}, 64'(rt_out_valid), 64'd1);
        chk({req, " rt_out_ltag"},  64'(rt_out_ltag),  64'(tag));
        chk({req, " rt_fault"},     64'(rt_fault),     64'(e_fault));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rt_out_valid after reset", 64'(rt_out_valid), 64'd0);
        chk("R1 rt_fault after reset",     64'(rt_fault),     64'd0);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            unique case (VECS[k].op)
                OP_FILL:  do_fill(VECS[k].va[47:12], VECS[k].ppn);
                OP_FLUSH: do_flush();
                default:  do_look($sformatf("R2-table vec%0d", k), VECS[k].va, 4'd0,
                                  VECS[k].e_hit, VECS[k].e_nc, VECS[k].ppn);
            endcase
        end

        // R7 / R12 retire path
        do_fill(36'h0_0000_0042, 28'h0000042);
        do_look("R5 alias tag3", 64'h1234_0000_0004_2000, 4'd3, 1'b1, 1'b1, 28'h0000042);
        do_look("R7 clean tag5", 64'h0000_0000_0004_2000, 4'd5, 1'b1, 1'b0, 28'h0000042);
        chk("R7 no output before retire", 64'(rt_out_valid), 64'd0);
        do_retire("R7 tag3 faults", 4'd3, 1'b1);
        do_retire("R7 tag5 clean",  4'd5, 1'b0);
        do_retire("R12 idle tag3",  4'd3, 1'b0);
        do_look("R7 miss noncanon tag9", 64'h8000_0000_0000_9000, 4'd9, 1'b0, 1'b1, 28'h0);
        do_retire("R7 tag9 faults after miss", 4'd9, 1'b1);
        do_retire("R12 never used tag14", 4'd14, 1'b0);
        chk("R7 fault drops when idle", 64'(rt_fault), 64'(rt_out_valid & rt_fault));

        // R9 overwrite keeps pointer
        do_flush();
        do_fill(36'd100, 28'h0000001);
        do_fill(36'd100, 28'h0000002);
        do_look("R9 overwrite ppn", {16'h0, 36'd100, 12'h0}, 4'd1, 1'b1, 1'b0, 28'h0000002);
        for (int v = 1; v <= 15; v++) begin
            do_fill(36'(v), 28'(v + 16'h100));
        end
        do_look("R9 survives 15 more fills", {16'h0, 36'd100, 12'h0}, 4'd1, 1'b1, 1'b0, 28'h0000002);
        do_look("R10 entry 15 present", {16'h0, 36'd15, 12'h0}, 4'd1, 1'b1, 1'b0, 28'h000010F);

        // R10 round-robin eviction of entry 0
        do_fill(36'd16, 28'h0000110);
        do_look("R10 oldest evicted", {16'h0, 36'd100, 12'h0}, 4'd1, 1'b0, 1'b0, 28'h0);
        do_look("R10 second kept",    {16'h0, 36'd1,   12'h0}, 4'd1, 1'b1, 1'b0, 28'h0000101);
        do_look("R10 newest present", {16'h0, 36'd16,  12'h0}, 4'd1, 1'b1, 1'b0, 28'h0000110);
        do_fill(36'd17, 28'h0000111);
        do_look("R10 next victim",    {16'h0, 36'd1,   12'h0}, 4'd1, 1'b0, 1'b0, 28'h0);

        // R11 fill and flush together
        fill_valid = 1'b1;
        fill_vpn   = 36'd200;
        fill_ppn   = 28'h00000C8;
        flush      = 1'b1;
        tick();
        fill_valid = 1'b0;
        flush      = 1'b0;
        do_look("R11 fill dropped", {16'h0, 36'd200, 12'h0}, 4'd2, 1'b0, 1'b0, 28'h0);
        do_look("R8 old entry gone", {16'h0, 36'd2, 12'h0}, 4'd2, 1'b0, 1'b0, 28'h0);

        // R3 upper bits only differ, lookup without valid gives no spec
        do_fill(36'hF_FFFF_FFFF, 28'h0ABCDEF);
        lk_valid = 1'b0;
        lk_vaddr = 64'h0000_FFFF_FFFF_F123;
        #2;
        chk("R3 hit with valid low", 64'(lk_hit), 64'd1);
        chk("R1 no spec without valid", 64'(lk_spec_ok), 64'd0);
        do_look("R3 upper bits ignored", 64'h5555_FFFF_FFFF_F000, 4'd7, 1'b1, 1'b1, 28'h0ABCDEF);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule